// File: doc/BRIEF.md
# Read-to-Clear Interrupt Status Bank

This block collects twelve event sources of a serial bus controller into a raw status vector, qualifies them with a software mask and drives a single interrupt line. Ten of the sources are sticky. A one-cycle pulse sets the bit, and only a read of a clear address removes it. The other two sources, receive-full and transmit-empty, are level conditions that the block tracks and that software cannot clear.

Clearing is a side effect of reading. Each sticky source has its own clear address, so a handler can clear exactly the bits it has seen. One global clear address wipes every sticky bit at once. Because the global clear acts on whatever is set at the moment of the read, it also removes an event that arrived after the handler's status read. A transmit-abort cause vector is captured with the abort status bit. It stays readable until the abort bit is cleared, and it is zeroed together with that bit.

The register bus is a plain strobe interface. Read data is combinational from the address, and every clear takes effect at the clock edge that ends the read cycle.

Top module: `irq_status_bank`

## Requirements
- R1: A high cycle on a sticky source input (bits 0,1,3,5,6,7,8,9,10,11 of `evt_in`) sets that raw status bit at the next clock edge. The bit then stays set until it is cleared.
- R2: Raw bits 2 (receive-full) and 4 (transmit-empty) copy `evt_in[2]` and `evt_in[4]` one cycle later. No clear read changes them.
- R3: Writing byte address 0x30 loads the 12-bit mask from `wdata`. Reading 0x30 returns it.
- R4: Reading 0x34 returns the raw status. Reading 0x2C returns the raw status ANDed with the mask.
- R5: `irq` is high exactly when some raw bit is set whose mask bit is set.
- R6: Each sticky source has its own clear address: bit0 0x44, bit1 0x48, bit3 0x4C, bit5 0x50, bit6 0x54, bit7 0x58, bit8 0x5C, bit9 0x60, bit10 0x64, bit11 0x68. Reading one returns the pre-clear value of its bit in data bit 0 and clears only that bit.
- R7: Reading 0x40 clears every sticky bit that is set. It returns 1 in data bit 0 if any sticky bit was pending, and 0 otherwise.
- R8: When a source pulse and a clear read of the same bit fall in the same cycle, the bit stays set.
- R9: The abort cause register is read at 0x80. It ORs in `abort_cause` on each bit-6 event, holds its value while bit 6 is set, and becomes zero when a clear read (0x54 or 0x40) removes bit 6.
- R10: After reset, the raw status, the mask, the abort cause and `irq` are all zero. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Read strobe. Clear side effects occur at the edge ending the cycle |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 12 | Write data (mask) |
| rdata | output | DATA_W | Combinational read data |
| evt_in | input | 12 | Event pulses (sticky bits) and levels (bits 2, 4) |
| abort_cause | input | CAUSE_W | Abort cause bits, sampled with `evt_in[6]` |
| irq | output | 1 | Interrupt request |

## Verification
A wrong raw or cause state is visible at the ports on the next read of 0x34, 0x2C or 0x80. A wrong raw bit also appears on `irq` within one cycle whenever its mask bit is set. Clear faults that hit the wrong bit show up as an unexpected survivor or a missing bit in the raw read that follows each clear. A lost same-cycle event is seen one cycle after the colliding read. Cause faults are checked across accumulation, a clear by the dedicated address and a clear by the global address.

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int CAUSE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [11:0]        wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [11:0]        evt_in,
  input  logic [CAUSE_W-1:0] abort_cause,
  output logic               irq
);
  localparam int NSRC = 12;
  localparam logic [NSRC-1:0] LEVEL_BITS = 12'h014;
  localparam logic [NSRC-1:0] SOFT_BITS  = ~LEVEL_BITS;
  localparam int ABORT_BIT = 6;

  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(8'h2C);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(8'h34);
  localparam logic [ADDR_W-1:0] A_GCLR  = ADDR_W'(8'h40);
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(8'h80);

  logic [NSRC-1:0]    raw_q, mask_q, clr_vec, sel_vec;
  logic [CAUSE_W-1:0] cause_q;

  function automatic logic [NSRC-1:0] clr_sel(input logic [ADDR_W-1:0] a);
    logic [NSRC-1:0] s;
    s = '0;
    case (a)
      ADDR_W'(8'h44): s[0]  = 1'b1;
      ADDR_W'(8'h48): s[1]  = 1'b1;
      ADDR_W'(8'h4C): s[3]  = 1'b1;
      ADDR_W'(8'h50): s[5]  = 1'b1;
      ADDR_W'(8'h54): s[6]  = 1'b1;
      ADDR_W'(8'h58): s[7]  = 1'b1;
      ADDR_W'(8'h5C): s[8]  = 1'b1;
      ADDR_W'(8'h60): s[9]  = 1'b1;
      ADDR_W'(8'h64): s[10] = 1'b1;
      ADDR_W'(8'h68): s[11] = 1'b1;
      default:        s     = '0;
    endcase
    return s;
  endfunction

  assign sel_vec = clr_sel(addr);
  assign clr_vec = !rd_en ? '0 : (addr == A_GCLR) ? SOFT_BITS : sel_vec;
  assign irq     = |(raw_q & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
    end else begin
      raw_q <= (((raw_q & ~clr_vec) | evt_in) & SOFT_BITS) | (evt_in & LEVEL_BITS);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (wr_en && addr == A_MASK) begin
      mask_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
    end else if (evt_in[ABORT_BIT]) begin
      cause_q <= cause_q | abort_cause;
    end else if (clr_vec[ABORT_BIT]) begin
      cause_q <= '0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_STAT:  rdata = DATA_W'(raw_q & mask_q);
      A_MASK:  rdata = DATA_W'(mask_q);
      A_RAW:   rdata = DATA_W'(raw_q);
      A_GCLR:  rdata[0] = |(raw_q & SOFT_BITS);
      A_CAUSE: rdata = DATA_W'(cause_q);
      default: rdata[0] = |(raw_q & sel_vec);
    endcase
  end
endmodule

module irq_status_bank_chk #(
  parameter int ADDR_W  = 8,
  parameter int CAUSE_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rd_en,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [11:0]        wdata,
  input logic [11:0]        evt_in,
  input logic [11:0]        raw,
  input logic [11:0]        mask,
  input logic [CAUSE_W-1:0] cause
);
  localparam logic [11:0] SOFT = 12'hFEB;

  assert_sticky_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    |(evt_in & SOFT) |=> ((raw & $past(evt_in & SOFT)) == $past(evt_in & SOFT)));

  assert_level_track_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (raw[2] == $past(evt_in[2]) && raw[4] == $past(evt_in[4])));

  assert_mask_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(8'h30)) |=> (mask == $past(wdata)));

  assert_single_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(8'h44) && !evt_in[0]) |=> !raw[0]);

  assert_others_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(8'h44)) |=> ((($past(raw) & SOFT & 12'hFFE) & ~raw) == 12'h000));

  assert_global_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(8'h40)) |=> (((raw & SOFT) & ~$past(evt_in)) == 12'h000));

  assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(8'h60) && evt_in[9]) |=> raw[9]);

  assert_cause_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !raw[6] |-> (cause == '0));

  assert_cause_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (raw[6] && !(rd_en && (addr == ADDR_W'(8'h54) || addr == ADDR_W'(8'h40))))
      |=> ((cause & $past(cause)) == $past(cause)));
endmodule

bind irq_status_bank irq_status_bank_chk #(.ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .evt_in(evt_in), .raw(raw_q), .mask(mask_q), .cause(cause_q)
);

// File: tb/irq_status_bank_tb.sv
module irq_status_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [11:0] wdata = '0;
  logic [31:0] rdata;
  logic [11:0] evt_in = '0;
  logic [15:0] abort_cause = '0;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  irq_status_bank u_dut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt_in(evt_in), .abort_cause(abort_cause), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0; addr = '0;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [11:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = '0;
  endtask

  task automatic pulse(input logic [11:0] ev, input logic [15:0] cause);
    @(negedge clk);
    evt_in = ev; abort_cause = cause;
    @(negedge clk);
    evt_in = '0; abort_cause = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R10 irq after reset", {31'b0, irq}, 32'h0);
    bus_read(8'h34, d); check("R10 raw after reset", d, 32'h0);
    bus_read(8'h30, d); check("R10 mask after reset", d, 32'h0);
    bus_read(8'h80, d); check("R10 cause after reset", d, 32'h0);
    bus_read(8'h10, d); check("R10 unmapped reads zero", d, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    @(negedge clk); evt_in = 12'h014;
    bus_read(8'h34, d); check("R2 level bits follow input", d, 32'h014);
    bus_read(8'h40, d); check("R2 global clear sees no sticky bit", d, 32'h0);
    bus_read(8'h34, d); check("R2 level bits survive global clear", d, 32'h014);
    @(negedge clk); evt_in = '0;
    bus_read(8'h34, d); check("R2 level bits drop with input", d, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    pulse(12'h201, 16'h0);
    bus_read(8'h34, d); check("R1 pulses latched", d, 32'h201);
    check("R5 irq low with mask zero", {31'b0, irq}, 32'h0);
    bus_write(8'h30, 12'h200);
    bus_read(8'h30, d); check("R3 mask readback", d, 32'h200);
    bus_read(8'h2C, d); check("R4 masked status", d, 32'h200);
    check("R5 irq high on unmasked bit", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_per_source();
    logic [31:0] d;
    bus_read(8'h44, d); check("R6 clear returns pending bit0", d, 32'h1);
    bus_read(8'h34, d); check("R6 only bit0 cleared", d, 32'h200);
    bus_read(8'h44, d); check("R6 second clear returns zero", d, 32'h0);
    bus_read(8'h60, d); check("R6 clear bit9 returns one", d, 32'h1);
    #1 check("R5 irq drops after clear", {31'b0, irq}, 32'h0);
    bus_read(8'h34, d); check("R6 raw empty", d, 32'h0);
  endtask

  task automatic t_global();
    logic [31:0] d;
    pulse(12'h8A1, 16'h0);
    bus_read(8'h34, d); check("R1 several pulses latched", d, 32'h8A1);
    bus_read(8'h40, d); check("R7 global returns pending", d, 32'h1);
    bus_read(8'h34, d); check("R7 global cleared all", d, 32'h0);
    bus_read(8'h40, d); check("R7 global returns zero when idle", d, 32'h0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    @(negedge clk);
    rd_en = 1'b1; addr = 8'h60; evt_in = 12'h200;
    #1 check("R8 clear read pre-value", rdata, 32'h0);
    @(negedge clk);
    rd_en = 1'b0; addr = '0; evt_in = '0;
    bus_read(8'h34, d); check("R8 event wins over clear", d, 32'h200);
    bus_read(8'h60, d); check("R8 later clear works", d, 32'h1);
  endtask

  task automatic t_abort();
    logic [31:0] d;
    pulse(12'h040, 16'h0011);
    pulse(12'h040, 16'h0100);
    bus_read(8'h80, d); check("R9 cause accumulates", d, 32'h0111);
    pulse(12'h001, 16'hFFFF);
    bus_read(8'h80, d); check("R9 cause held without abort event", d, 32'h0111);
    bus_read(8'h54, d); check("R9 abort clear returns one", d, 32'h1);
    bus_read(8'h80, d); check("R9 cause zeroed by abort clear", d, 32'h0);
    bus_read(8'h34, d); check("R9 other bit kept", d, 32'h001);
    pulse(12'h040, 16'h0005);
    bus_read(8'h80, d); check("R9 cause captured again", d, 32'h0005);
    bus_read(8'h40, d);
    bus_read(8'h80, d); check("R9 cause zeroed by global clear", d, 32'h0);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_level();
    t_mask();
    t_per_source();
    t_global();
    t_race();
    t_abort();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule